// File: doc/BRIEF.md
# Large-Page NAND Target Command Decoder

This block sits on the device side of a byte-wide NAND bus and turns the stream of command, address and data writes into decoded operations. Each byte is taken when the active-low write strobe rises; the command-latch and address-latch enables classify it. The decoder follows each multi-byte operation through its phases (opening command, address cycles, optional data, closing command) and reports a finished operation as a one-cycle pulse with an operation code and the captured column and row address.

There is no flash array here. An operation that would occupy the array loads a down-counter from a programmable length, and the ready output stays low until that counter drains. While not ready, only the status-read and reset commands get through; every other write is silently dropped. An ill-formed sequence raises a one-cycle error pulse and returns the decoder to idle. The reset command (FFh) always ends any open sequence.

Top module: `nand_cmd_decoder`

## Requirements
- R1: After reset, op_valid and seq_err are 0, rdy is 1, op_code is 0 and both address outputs are 0.
- R2: A byte is taken on the clock edge that first sees we_n high after it was low. cle=1 with ale=0 marks a command and ale=1 with cle=0 marks an address. Both low marks data, and both high is ignored. Results appear on that same edge.
- R3: 00h, two column cycles, two row cycles, then 30h gives op_code 1 (page read). 35h as the closing byte gives 2 (read for internal move). Column cycle 1 gives column bits 7:0. Column cycle 2 gives bits 11:8 from io[3:0], with io[7:4] ignored. Row cycle 1 gives the low row byte and row cycle 2 the high one.
- R4: 80h, four address cycles, any data bytes, then 10h gives op_code 3 (program). 15h as the closing byte gives 4 (cache program). 85h opening from idle and closed by 10h gives 5 (program for internal move).
- R5: Inside an open program's data phase, 85h followed by two column cycles gives op_code 8 (random data input) with the new column. The program stays open, and a later 10h still completes it.
- R6: 60h, two row cycles, then D0h gives op_code 6 (block erase) and leaves the column output unchanged.
- R7: 05h, two column cycles, then E0h gives op_code 8'h07 (random data read). It does not drop rdy.
- R8: Single-byte commands complete at once: 31h gives 9, 3Fh gives 10, 90h gives 11, 70h gives 12 and FFh gives 13.
- R9: The closing bytes 30h, 35h, 10h, 15h and D0h, and the reset command FFh, load busy_len. rdy is then 0 for exactly busy_len clock cycles.
- R10: While rdy is 0, only 70h and FFh are accepted. Other commands, address bytes and data bytes cause no op_valid and no seq_err, and leave the addresses unchanged.
- R11: A closing byte that does not fit the open command, a command before all address cycles are in, an unknown opening byte, or a data byte during the address or closing phases all pulse seq_err and return the decoder to idle.
- R12: An address byte with no address phase open (in idle, or after the last expected cycle) pulses seq_err.
- R13: FFh ends any partial sequence with op_code 13 and no seq_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Active-low write strobe; a byte is taken on its rising edge |
| io | input | 8 | Bus byte |
| busy_len | input | CNT_W (16) | Busy length in clock cycles |
| op_valid | output | 1 | One-cycle pulse: operation decoded |
| op_code | output | 4 | Code of the last decoded operation |
| col_addr | output | COL_W (12) | Captured column address |
| row_addr | output | 8*ROW_CYC (16) | Captured row address |
| seq_err | output | 1 | One-cycle pulse: sequence error |
| rdy | output | 1 | 1 when not busy |

## Verification
Every result is registered on the edge where the rising write strobe is seen, so op_valid, seq_err and the addresses are due one edge after the bench releases we_n. Each bench write ends on the falling edge after that edge, which is where the one-cycle pulses are read. rdy falls on the edge that takes a closing byte and comes back busy_len edges later. The bench counts falling edges from the end of the write to confirm it is low on the last busy cycle and high on the next one.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

   typedef enum logic [3:0] {
      OP_NONE       = 4'd0,
      OP_PAGE_READ  = 4'd1,
      OP_READ_MOVE  = 4'd2,
      OP_PROG       = 4'd3,
      OP_PROG_CACHE = 4'd4,
      OP_PROG_MOVE  = 4'd5,
      OP_ERASE      = 4'd6,
      OP_RAND_READ  = 4'd7,
      OP_RAND_IN    = 4'd8,
      OP_CACHE_RD   = 4'd9,
      OP_CACHE_LAST = 4'd10,
      OP_READ_ID    = 4'd11,
      OP_STATUS     = 4'd12,
      OP_RESET      = 4'd13
   } op_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CONF,
      PH_DATA,
      PH_RADDR
   } phase_e;

   localparam logic [7:0] C_READ     = 8'h00;
   localparam logic [7:0] C_READ_GO  = 8'h30;
   localparam logic [7:0] C_MOVE_GO  = 8'h35;
   localparam logic [7:0] C_PROG     = 8'h80;
   localparam logic [7:0] C_PROG_GO  = 8'h10;
   localparam logic [7:0] C_CACHE_GO = 8'h15;
   localparam logic [7:0] C_MOVE_IN  = 8'h85;
   localparam logic [7:0] C_ERASE    = 8'h60;
   localparam logic [7:0] C_ERASE_GO = 8'hD0;
   localparam logic [7:0] C_RND_RD   = 8'h05;
   localparam logic [7:0] C_RND_GO   = 8'hE0;
   localparam logic [7:0] C_CRD      = 8'h31;
   localparam logic [7:0] C_CLAST    = 8'h3F;
   localparam logic [7:0] C_ID       = 8'h90;
   localparam logic [7:0] C_STAT     = 8'h70;
   localparam logic [7:0] C_RST      = 8'hFF;

endpackage

// File: rtl/nand_bus_strobe.sv
module nand_bus_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic cle,
   input  logic ale,
   input  logic we_n,
   output logic stb_cmd,
   output logic stb_addr,
   output logic stb_data
);
   logic we_prev_q;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_prev_q <= 1'b1;
      else        we_prev_q <= we_n;
   end

   // R2: the byte is taken on the edge that sees the strobe return high
   assign rise     = !we_prev_q && we_n;
   assign stb_cmd  = rise &&  cle && !ale;
   assign stb_addr = rise &&  ale && !cle;
   assign stb_data = rise && !cle && !ale;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             rdy
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("nand_busy_timer: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign rdy = (cnt_q == '0);

   p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load && load_val != '0 |=> !rdy);

   p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !rdy |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
   import nand_dec_pkg::*;
#(
   parameter int COL_W   = 12,
   parameter int ROW_CYC = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stb_cmd,
   input  logic                 stb_addr,
   input  logic                 stb_data,
   input  logic [7:0]           io,
   input  logic                 rdy,
   output logic                 op_valid,
   output logic [3:0]           op_code,
   output logic [COL_W-1:0]     col_addr,
   output logic [8*ROW_CYC-1:0] row_addr,
   output logic                 seq_err,
   output logic                 busy_load
);
   localparam int COL_CYC = 2;
   localparam int ROW_W   = 8 * ROW_CYC;
   localparam int AW      = $clog2(COL_CYC + ROW_CYC + 1);
   localparam logic [AW-1:0] N_FULL = AW'(COL_CYC + ROW_CYC);
   localparam logic [AW-1:0] N_COL  = AW'(COL_CYC);
   localparam logic [AW-1:0] N_ROW  = AW'(ROW_CYC);

   if (COL_W <= 8 || COL_W > 16) begin : g_bad_col
      $error("nand_seq_fsm: COL_W must span two column cycles");
   end
   if (ROW_CYC < 1 || ROW_CYC > 4) begin : g_bad_row
      $error("nand_seq_fsm: ROW_CYC out of range");
   end

   phase_e           phase_q, phase_d;
   logic [7:0]       first_q, first_d;
   logic [AW-1:0]    acnt_q, acnt_d, aneed_q, aneed_d;
   op_e              op_q, op_d;
   logic             opv_q, opv_d, err_q, err_d;
   logic             cmd_ok, addr_live, is_erase, addr_is_col;
   logic             col_we_lo, col_we_hi;
   logic [AW-1:0]    row_idx;
   logic [ROW_CYC-1:0] row_we;
   logic [COL_W-1:0] col_q, col_d;
   logic [ROW_W-1:0] row_q, row_d;

   // R10: while busy only status read and reset pass the filter
   assign cmd_ok      = stb_cmd && (rdy || io == C_STAT || io == C_RST);
   assign addr_live   = stb_addr && rdy && (phase_q == PH_ADDR || phase_q == PH_RADDR);
   assign is_erase    = (first_q == C_ERASE);
   assign addr_is_col = !is_erase && (acnt_q < N_COL);
   assign row_idx     = is_erase ? acnt_q : acnt_q - N_COL;

   // R3: column cycle 2 supplies the upper column bits from the low io lines
   assign col_we_lo = addr_live && addr_is_col && (acnt_q == '0);
   assign col_we_hi = addr_live && addr_is_col && (acnt_q == AW'(1));
   assign col_d = col_we_lo ? {col_q[COL_W-1:8], io} :
                  col_we_hi ? {io[COL_W-9:0], col_q[7:0]} : col_q;

   for (genvar g = 0; g < ROW_CYC; g++) begin : g_row_byte
      assign row_we[g]          = addr_live && !addr_is_col && (row_idx == AW'(g));
      assign row_d[8*g +: 8]    = row_we[g] ? io : row_q[8*g +: 8];
   end

   always_comb begin
      phase_d   = phase_q;
      first_d   = first_q;
      acnt_d    = acnt_q;
      aneed_d   = aneed_q;
      op_d      = op_q;
      opv_d     = 1'b0;
      err_d     = 1'b0;
      busy_load = 1'b0;
      if (cmd_ok) begin
         if (io == C_RST) begin
            phase_d   = PH_IDLE;
            op_d      = OP_RESET;
            opv_d     = 1'b1;
            busy_load = 1'b1;
         end else begin
            unique case (phase_q)
               PH_IDLE: begin
                  first_d = io;
                  acnt_d  = '0;
                  unique case (io)
                     C_READ, C_PROG, C_MOVE_IN: begin phase_d = PH_ADDR; aneed_d = N_FULL; end
                     C_ERASE:  begin phase_d = PH_ADDR; aneed_d = N_ROW; end
                     C_RND_RD: begin phase_d = PH_ADDR; aneed_d = N_COL; end
                     C_CRD:    begin op_d = OP_CACHE_RD;   opv_d = 1'b1; end
                     C_CLAST:  begin op_d = OP_CACHE_LAST; opv_d = 1'b1; end
                     C_ID:     begin op_d = OP_READ_ID;    opv_d = 1'b1; end
                     C_STAT:   begin op_d = OP_STATUS;     opv_d = 1'b1; end
                     default:  err_d = 1'b1;
                  endcase
               end
               PH_CONF: begin
                  phase_d = PH_IDLE;
                  if (first_q == C_READ && io == C_READ_GO) begin
                     op_d = OP_PAGE_READ; opv_d = 1'b1; busy_load = 1'b1;
                  end else if (first_q == C_READ && io == C_MOVE_GO) begin
                     op_d = OP_READ_MOVE; opv_d = 1'b1; busy_load = 1'b1;
                  end else if (first_q == C_ERASE && io == C_ERASE_GO) begin
                     op_d = OP_ERASE; opv_d = 1'b1; busy_load = 1'b1;
                  end else if (first_q == C_RND_RD && io == C_RND_GO) begin
                     op_d = OP_RAND_READ; opv_d = 1'b1;
                  end else begin
                     err_d = 1'b1;
                  end
               end
               PH_DATA: begin
                  if (io == C_MOVE_IN) begin
                     phase_d = PH_RADDR;
                     acnt_d  = '0;
                     aneed_d = N_COL;
                  end else if (io == C_PROG_GO) begin
                     phase_d = PH_IDLE;
                     op_d = (first_q == C_PROG) ? OP_PROG : OP_PROG_MOVE;
                     opv_d = 1'b1; busy_load = 1'b1;
                  end else if (io == C_CACHE_GO && first_q == C_PROG) begin
                     phase_d = PH_IDLE;
                     op_d = OP_PROG_CACHE; opv_d = 1'b1; busy_load = 1'b1;
                  end else begin
                     phase_d = PH_IDLE;
                     err_d   = 1'b1;
                  end
               end
               default: begin
                  phase_d = PH_IDLE;
                  err_d   = 1'b1;
               end
            endcase
         end
      end else if (stb_addr && rdy) begin
         if (addr_live) begin
            acnt_d = AW'(acnt_q + 1'b1);
            if (AW'(acnt_q + 1'b1) == aneed_q) begin
               if (phase_q == PH_RADDR) begin
                  phase_d = PH_DATA;
                  op_d    = OP_RAND_IN;
                  opv_d   = 1'b1;
               end else if (first_q == C_PROG || first_q == C_MOVE_IN) begin
                  phase_d = PH_DATA;
               end else begin
                  phase_d = PH_CONF;
               end
            end
         end else begin
            phase_d = PH_IDLE;
            err_d   = 1'b1;
         end
      end else if (stb_data && rdy) begin
         if (phase_q == PH_ADDR || phase_q == PH_RADDR || phase_q == PH_CONF) begin
            phase_d = PH_IDLE;
            err_d   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         first_q <= '0;
         acnt_q  <= '0;
         aneed_q <= '0;
         op_q    <= OP_NONE;
         opv_q   <= 1'b0;
         err_q   <= 1'b0;
         col_q   <= '0;
         row_q   <= '0;
      end else begin
         phase_q <= phase_d;
         first_q <= first_d;
         acnt_q  <= acnt_d;
         aneed_q <= aneed_d;
         op_q    <= op_d;
         opv_q   <= opv_d;
         err_q   <= err_d;
         col_q   <= col_d;
         row_q   <= row_d;
      end
   end

   assign op_valid = opv_q;
   assign op_code  = op_q;
   assign seq_err  = err_q;
   assign col_addr = col_q;
   assign row_addr = row_q;

   p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stb_cmd && !rdy && io != C_STAT && io != C_RST
      |=> !op_valid && !seq_err && phase_q == $past(phase_q));

   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stb_addr && !rdy |=> col_q == $past(col_q) && row_q == $past(row_q));

   p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
      stb_cmd && io == C_RST |=> op_valid && op_q == OP_RESET && phase_q == PH_IDLE && !seq_err);

   p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> phase_q == PH_IDLE);

   p_no_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && seq_err));

   p_load_reports_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_load |=> op_valid);
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder #(
   parameter int COL_W   = 12,
   parameter int ROW_CYC = 2,
   parameter int CNT_W   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cle,
   input  logic                 ale,
   input  logic                 we_n,
   input  logic [7:0]           io,
   input  logic [CNT_W-1:0]     busy_len,
   output logic                 op_valid,
   output logic [3:0]           op_code,
   output logic [COL_W-1:0]     col_addr,
   output logic [8*ROW_CYC-1:0] row_addr,
   output logic                 seq_err,
   output logic                 rdy
);
   logic stb_cmd, stb_addr, stb_data, busy_load;

   nand_bus_strobe u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .cle      (cle),
      .ale      (ale),
      .we_n     (we_n),
      .stb_cmd  (stb_cmd),
      .stb_addr (stb_addr),
      .stb_data (stb_data)
   );

   nand_seq_fsm #(.COL_W(COL_W), .ROW_CYC(ROW_CYC)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_cmd   (stb_cmd),
      .stb_addr  (stb_addr),
      .stb_data  (stb_data),
      .io        (io),
      .rdy       (rdy),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .col_addr  (col_addr),
      .row_addr  (row_addr),
      .seq_err   (seq_err),
      .busy_load (busy_load)
   );

   nand_busy_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (busy_load),
      .load_val (busy_len),
      .rdy      (rdy)
   );
endmodule

// File: tb/nand_cmd_decoder_tb_top.sv
module nand_cmd_decoder_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cle = 1'b0, ale = 1'b0, we_n = 1'b1;
   logic [7:0]  io = 8'h00;
   logic [15:0] busy_len = 16'd0;
   logic        op_valid, seq_err, rdy;
   logic [3:0]  op_code;
   logic [11:0] col_addr;
   logic [15:0] row_addr;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_cmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .io(io),
      .busy_len(busy_len), .op_valid(op_valid), .op_code(op_code),
      .col_addr(col_addr), .row_addr(row_addr), .seq_err(seq_err), .rdy(rdy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic c, input logic a, input logic [7:0] b);
      @(negedge clk); cle = c; ale = a; io = b; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); cle = 1'b0; ale = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] b); wr(1'b1, 1'b0, b); endtask
   task automatic adr(input logic [7:0] b); wr(1'b0, 1'b1, b); endtask
   task automatic dat(input logic [7:0] b); wr(1'b0, 1'b0, b); endtask

   task automatic t_reset;
      chk("R1 op_valid", op_valid, 0);
      chk("R1 seq_err", seq_err, 0);
      chk("R1 rdy", rdy, 1);
      chk("R1 op_code", op_code, 0);
      chk("R1 col", col_addr, 0);
      chk("R1 row", row_addr, 0);
   endtask

   task automatic t_latch;
      @(negedge clk); cle = 1'b1; io = 8'h90; we_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2 no take while low", op_valid, 0);
      end
      we_n = 1'b1;
      @(negedge clk);
      chk("R2 take on rise valid", op_valid, 1);
      chk("R2 take on rise code", op_code, 11);
      cle = 1'b0;
      wr(1'b1, 1'b1, 8'h00);
      chk("R2 both high no op", op_valid, 0);
      chk("R2 both high no err", seq_err, 0);
      dat(8'h5A);
      chk("R2 idle data no err", seq_err, 0);
   endtask

   task automatic t_page_read;
      cmd(8'h00); adr(8'h34); adr(8'hF5); adr(8'h78); adr(8'h9A);
      chk("R3 no op before confirm", op_valid, 0);
      cmd(8'h30);
      chk("R3 read valid", op_valid, 1);
      chk("R3 read code", op_code, 1);
      chk("R3 column", col_addr, 12'h534);
      chk("R3 row", row_addr, 16'h9A78);
      @(negedge clk);
      chk("R3 pulse one cycle", op_valid, 0);
      cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); cmd(8'h35);
      chk("R3 move read code", op_code, 2);
      chk("R3 move column", col_addr, 12'h201);
   endtask

   task automatic t_program;
      cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h11); adr(8'h22);
      dat(8'hA1); dat(8'hA2); dat(8'hA3);
      chk("R4 data no err", seq_err, 0);
      cmd(8'h10);
      chk("R4 prog valid", op_valid, 1);
      chk("R4 prog code", op_code, 3);
      chk("R4 prog row", row_addr, 16'h2211);
      cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00); adr(8'h00); dat(8'h01); cmd(8'h15);
      chk("R4 cache prog code", op_code, 4);
      cmd(8'h85); adr(8'h00); adr(8'h00); adr(8'h05); adr(8'h00); cmd(8'h10);
      chk("R4 move prog code", op_code, 5);
      chk("R4 move prog row", row_addr, 16'h0005);
   endtask

   task automatic t_rand_in;
      cmd(8'h80); adr(8'h10); adr(8'h00); adr(8'h01); adr(8'h00); dat(8'h11);
      cmd(8'h85); adr(8'h20);
      chk("R5 no op mid column", op_valid, 0);
      adr(8'h03);
      chk("R5 rand in valid", op_valid, 1);
      chk("R5 rand in code", op_code, 8);
      chk("R5 rand in column", col_addr, 12'h320);
      dat(8'h22);
      cmd(8'h10);
      chk("R5 prog completes", op_code, 3);
      chk("R5 no err", seq_err, 0);
   endtask

   task automatic t_erase;
      cmd(8'h60); adr(8'h44); adr(8'h55); cmd(8'hD0);
      chk("R6 erase code", op_code, 6);
      chk("R6 erase row", row_addr, 16'h5544);
      chk("R6 column kept", col_addr, 12'h320);
   endtask

   task automatic t_rand_read;
      busy_len = 16'd5;
      cmd(8'h05); adr(8'h7F); adr(8'h06); cmd(8'hE0);
      chk("R7 rand read code", op_code, 7);
      chk("R7 rand read column", col_addr, 12'h67F);
      chk("R7 no busy", rdy, 1);
      busy_len = 16'd0;
   endtask

   task automatic t_single;
      cmd(8'h31); chk("R8 31h", op_code, 9);
      cmd(8'h3F); chk("R8 3Fh", op_code, 10);
      cmd(8'h90); chk("R8 90h", op_code, 11);
      cmd(8'h70); chk("R8 70h", op_code, 12);
      cmd(8'hFF); chk("R8 FFh", op_code, 13);
      chk("R8 FFh valid", op_valid, 1);
   endtask

   task automatic t_busy_len;
      busy_len = 16'd6;
      cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
      chk("R9 busy after confirm", rdy, 0);
      repeat (5) @(negedge clk);
      chk("R9 still busy last cycle", rdy, 0);
      @(negedge clk);
      chk("R9 ready after count", rdy, 1);
   endtask

   task automatic t_busy_filter;
      int n;
      busy_len = 16'd40;
      cmd(8'h00); adr(8'hAB); adr(8'h0C); adr(8'h12); adr(8'h34); cmd(8'h30);
      chk("R10 busy", rdy, 0);
      cmd(8'h90);
      chk("R10 dropped cmd no op", op_valid, 0);
      chk("R10 dropped cmd code kept", op_code, 1);
      chk("R10 dropped cmd no err", seq_err, 0);
      adr(8'h55);
      chk("R10 dropped addr col", col_addr, 12'hCAB);
      chk("R10 dropped addr row", row_addr, 16'h3412);
      chk("R10 dropped addr no err", seq_err, 0);
      dat(8'h66);
      chk("R10 dropped data no err", seq_err, 0);
      cmd(8'h70);
      chk("R10 status while busy", op_code, 12);
      chk("R10 status valid", op_valid, 1);
      cmd(8'hFF);
      chk("R10 reset while busy", op_code, 13);
      chk("R9 reset reloads busy", rdy, 0);
      n = 0;
      while (!rdy && n < 200) begin @(negedge clk); n++; end
      chk("R9 reset busy length", n, 40);
      busy_len = 16'd0;
   endtask

   task automatic t_errors;
      cmd(8'h00); adr(8'h01); adr(8'h02); cmd(8'h30);
      chk("R11 early confirm", seq_err, 1);
      cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); cmd(8'h10);
      chk("R11 mismatched confirm", seq_err, 1);
      chk("R11 no op on error", op_valid, 0);
      cmd(8'h00); adr(8'h11); adr(8'h02); adr(8'h03); adr(8'h04); cmd(8'h30);
      chk("R11 idle after error", op_code, 1);
      chk("R11 idle after error col", col_addr, 12'h211);
      cmd(8'hAB);
      chk("R11 unknown opener", seq_err, 1);
      cmd(8'h80); adr(8'h00); dat(8'h01);
      chk("R11 data in address phase", seq_err, 1);
      cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'h30);
      chk("R11 erase wrong confirm", seq_err, 1);
      adr(8'h09);
      chk("R12 address in idle", seq_err, 1);
      cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h05);
      chk("R12 extra address", seq_err, 1);
   endtask

   task automatic t_abort;
      cmd(8'h80); adr(8'h01); adr(8'h02);
      cmd(8'hFF);
      chk("R13 abort code", op_code, 13);
      chk("R13 abort no err", seq_err, 0);
      adr(8'h03);
      chk("R13 back in idle", seq_err, 1);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_page_read();
      t_program();
      t_rand_in();
      t_erase();
      t_rand_read();
      t_single();
      t_busy_len();
      t_busy_filter();
      t_errors();
      t_abort();
      done = 1'b1;
      finish_run();
   end
endmodule